// File: doc/BRIEF.md
# Peripheral Bus Address Map Unit

This block turns 18-bit addresses issued by DMA masters on a peripheral bus into 22-bit physical memory addresses. The five upper bus address bits pick one of 32 relocation entries. The 13-bit offset inside that 8 KB window is then added to the 22-bit relocation value held in the entry, so a DMA window can sit at any even physical address.

Software programs the entries through a small byte-addressed register port. Each entry takes two 16-bit words: the low word holds relocation bits 15:1 and the high word holds bits 21:16. The highest bus window is the I/O page. It is never relocated and is always steered to the top 8 KB of physical space. A global enable selects between relocation and plain zero extension. A fixed lower and upper limit mark a hole of bus addresses that is not passed to main memory.

Top module: `busmap_unit`

## Requirements
- R1: After reset every relocation entry is zero, every register read returns 0, and `phys_addr_o`, `io_page_o` and `mem_sel_o` are 0 until the first clock edge with `rst_ni` high.
- R2: A write to a low word stores `reg_wdata_i[15:1]` as relocation bits 15:1. Relocation bit 0 is always 0, and a low-word read returns `{bits 15:1, 1'b0}`.
- R3: A write to a high word stores `reg_wdata_i[5:0]` as relocation bits 21:16. A high-word read returns those bits in `[5:0]`, with bits 15:6 reading as 0.
- R4: The register byte address decodes as follows: bits 6:2 give the entry index, bit 1 selects the word (0 = low, 1 = high), and bit 0 is ignored.
- R5: With `map_en_i`=1 and the bus window index (bits 17:13) not equal to 31, `phys_addr_o` equals the selected entry's relocation value plus `bus_addr_i[12:0]`, modulo 2^22.
- R6: With `map_en_i`=0 and the window index not equal to 31, `phys_addr_o` equals `bus_addr_i` zero-extended to 22 bits.
- R7: A window index of 31 (the I/O page) sets `io_page_o`=1 and gives `phys_addr_o` = `22'h3FE000 | bus_addr_i[12:0]`, whatever the value of `map_en_i` and whatever entry 31 holds.
- R8: `mem_sel_o` is 0 when the bus address lies in `[LO_LIMIT, HI_LIMIT]` (defaults 18'h30000 and 18'h33FFF, both inclusive) or in the I/O page. Otherwise it is 1.
- R9: All three translation outputs are registered. They reflect the inputs sampled at the previous rising clock edge, together with the entry contents at that edge.
- R10: A write to one entry word leaves all other entry words unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_addr_i | input | 18 | Peripheral bus DMA address |
| map_en_i | input | 1 | Relocation enable |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 7 | Register byte address within the map block |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Register read data (combinational from `reg_addr_i`) |
| phys_addr_o | output | 22 | Translated physical address |
| io_page_o | output | 1 | Address lies in the I/O page |
| mem_sel_o | output | 1 | Address is passed to main memory |

## Verification
The hardest case to reach is the 22-bit wrap of the relocation sum. It needs an entry loaded with the largest even relocation value through two separate word writes, followed by a bus offset large enough to carry out of bit 21. The bench programs both words of an entry to all ones and then issues an offset that overflows. It also shows that entry 31 is ignored by loading it with a non-zero value before driving I/O page addresses with relocation on. The limit hole is probed one address below, at, and one address above each edge.

// File: rtl/busmap_pkg.sv
package busmap_pkg;
  typedef enum logic {
    WORD_LO = 1'b0,
    WORD_HI = 1'b1
  } map_word_e;
endpackage

// File: rtl/busmap_regfile.sv
module busmap_regfile
  import busmap_pkg::*;
#(
  parameter int N_ENT   = 32,
  parameter int IDX_W   = 5,
  parameter int PHYS_AW = 22,
  parameter int DATA_W  = 16
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            wr_en_i,
  input  logic [IDX_W+1:0]                addr_i,
  input  logic [DATA_W-1:0]               wdata_i,
  output logic [DATA_W-1:0]               rdata_o,
  output logic [N_ENT-1:0][PHYS_AW-1:0]   reloc_o
);
  localparam int HI_W = PHYS_AW - DATA_W;

  logic [IDX_W-1:0] idx;
  map_word_e        word_sel;
  logic [PHYS_AW-1:0] sel_val;

  assign idx      = addr_i[IDX_W+1:2];
  assign word_sel = map_word_e'(addr_i[1]);

  for (genvar e = 0; e < N_ENT; e++) begin : g_ent
    logic [DATA_W-2:0] lo_q;
    logic [HI_W-1:0]   hi_q;
    logic              hit;
    assign hit = wr_en_i && (idx == IDX_W'(e));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        lo_q <= '0;
        hi_q <= '0;
      end else if (hit) begin
        if (word_sel == WORD_HI) hi_q <= wdata_i[HI_W-1:0];
        else                     lo_q <= wdata_i[DATA_W-1:1];
      end
    end

    assign reloc_o[e] = {hi_q, lo_q, 1'b0};
  end

  assign sel_val = reloc_o[idx];

  always_comb begin
    if (word_sel == WORD_HI) rdata_o = {{(DATA_W-HI_W){1'b0}}, sel_val[PHYS_AW-1:DATA_W]};
    else                     rdata_o = sel_val[DATA_W-1:0];
  end

  // R3
  hi_word_pad_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_i[1] |-> rdata_o[DATA_W-1:HI_W] == '0);
endmodule

// File: rtl/busmap_xlate_core.sv
module busmap_xlate_core #(
  parameter int N_ENT     = 32,
  parameter int BUS_AW    = 18,
  parameter int PHYS_AW   = 22,
  parameter int PAGE_BITS = 13
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [BUS_AW-1:0]             bus_addr_i,
  input  logic                          map_en_i,
  input  logic [N_ENT-1:0][PHYS_AW-1:0] reloc_i,
  output logic                          io_page_o,
  output logic [PHYS_AW-1:0]            phys_q_o
);
  localparam int IDX_W = BUS_AW - PAGE_BITS;

  logic [IDX_W-1:0]     win;
  logic [PAGE_BITS-1:0] off;
  logic [PHYS_AW-1:0]   phys_d;

  assign win       = bus_addr_i[BUS_AW-1:PAGE_BITS];
  assign off       = bus_addr_i[PAGE_BITS-1:0];
  assign io_page_o = &win;

  always_comb begin
    if (io_page_o)
      phys_d = {{(PHYS_AW-PAGE_BITS){1'b1}}, off};
    else if (map_en_i)
      phys_d = reloc_i[win] + {{(PHYS_AW-PAGE_BITS){1'b0}}, off};
    else
      phys_d = {{(PHYS_AW-BUS_AW){1'b0}}, bus_addr_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) phys_q_o <= '0;
    else         phys_q_o <= phys_d;
  end

  // R5: relocation values are even, so bit 0 follows the offset
  reloc_lsb_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (map_en_i && !(&win)) |=> phys_q_o[0] == $past(bus_addr_i[0]));
  // R6
  passthru_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!map_en_i && !(&win)) |=> phys_q_o == {{(PHYS_AW-BUS_AW){1'b0}}, $past(bus_addr_i)});
endmodule

// File: rtl/busmap_limit.sv
module busmap_limit #(
  parameter int                BUS_AW   = 18,
  parameter logic [BUS_AW-1:0] LO_LIMIT = 18'h30000,
  parameter logic [BUS_AW-1:0] HI_LIMIT = 18'h33FFF
) (
  input  logic [BUS_AW-1:0] bus_addr_i,
  output logic              in_hole_o
);
  assign in_hole_o = (bus_addr_i >= LO_LIMIT) && (bus_addr_i <= HI_LIMIT);
endmodule

// File: rtl/busmap_unit.sv
module busmap_unit #(
  parameter int                BUS_AW    = 18,
  parameter int                PHYS_AW   = 22,
  parameter int                PAGE_BITS = 13,
  parameter int                DATA_W    = 16,
  parameter logic [BUS_AW-1:0] LO_LIMIT  = 18'h30000,
  parameter logic [BUS_AW-1:0] HI_LIMIT  = 18'h33FFF
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [17:0]        bus_addr_i,
  input  logic               map_en_i,
  input  logic               reg_wr_i,
  input  logic [6:0]         reg_addr_i,
  input  logic [15:0]        reg_wdata_i,
  output logic [15:0]        reg_rdata_o,
  output logic [21:0]        phys_addr_o,
  output logic               io_page_o,
  output logic               mem_sel_o
);
  localparam int IDX_W = BUS_AW - PAGE_BITS;
  localparam int N_ENT = 1 << IDX_W;

  logic [N_ENT-1:0][PHYS_AW-1:0] reloc;
  logic io_d, hole, io_q, mem_q;

  busmap_regfile #(
    .N_ENT(N_ENT), .IDX_W(IDX_W), .PHYS_AW(PHYS_AW), .DATA_W(DATA_W)
  ) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(reg_wr_i), .addr_i(reg_addr_i),
    .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o), .reloc_o(reloc)
  );

  busmap_xlate_core #(
    .N_ENT(N_ENT), .BUS_AW(BUS_AW), .PHYS_AW(PHYS_AW), .PAGE_BITS(PAGE_BITS)
  ) u_core (
    .clk_i(clk_i), .rst_ni(rst_ni), .bus_addr_i(bus_addr_i), .map_en_i(map_en_i),
    .reloc_i(reloc), .io_page_o(io_d), .phys_q_o(phys_addr_o)
  );

  busmap_limit #(
    .BUS_AW(BUS_AW), .LO_LIMIT(LO_LIMIT), .HI_LIMIT(HI_LIMIT)
  ) u_lim (
    .bus_addr_i(bus_addr_i), .in_hole_o(hole)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      io_q  <= 1'b0;
      mem_q <= 1'b0;
    end else begin
      io_q  <= io_d;
      mem_q <= !io_d && !hole;
    end
  end

  assign io_page_o = io_q;
  assign mem_sel_o = mem_q;

  // R7
  io_page_top_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    io_page_o |-> &phys_addr_o[PHYS_AW-1:PAGE_BITS]);
  // R8
  hole_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_addr_i >= LO_LIMIT && bus_addr_i <= HI_LIMIT) |=> !mem_sel_o);
endmodule

// File: tb/sim_busmap_unit.sv
module sim_busmap_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [17:0] bus_addr = '0;
  logic        map_en = 1'b0;
  logic        reg_wr = 1'b0;
  logic [6:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic [21:0] phys;
  logic        io_pg, mem_sel;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  busmap_unit u0 (
    .clk_i(clk), .rst_ni(rst_n), .bus_addr_i(bus_addr), .map_en_i(map_en),
    .reg_wr_i(reg_wr), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata),
    .reg_rdata_o(reg_rdata), .phys_addr_o(phys), .io_page_o(io_pg), .mem_sel_o(mem_sel)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [6:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [6:0] a, input logic [15:0] exp);
    @(negedge clk);
    reg_addr = a;
    #1;
    check(req, 32'(reg_rdata), 32'(exp));
  endtask

  task automatic xl(input logic [17:0] a, input logic en);
    @(negedge clk);
    bus_addr = a; map_en = en;
    @(negedge clk);
  endtask

  task automatic t_reset;
    check("R1 phys", 32'(phys), 0);
    check("R1 io", 32'(io_pg), 0);
    check("R1 mem_sel", 32'(mem_sel), 0);
    rd_chk("R1 entry0 lo", 7'd0, 16'h0000);
    rd_chk("R1 entry7 hi", 7'd30, 16'h0000);
  endtask

  task automatic t_regs;
    wr(7'd12, 16'hABCD);                 // entry 3 low
    wr(7'd14, 16'hFFFF);                 // entry 3 high
    rd_chk("R2 lo bit0 cleared", 7'd12, 16'hABCC);
    rd_chk("R3 hi pad", 7'd14, 16'h003F);
    rd_chk("R4 bit0 ignored on read", 7'd13, 16'hABCC);
    wr(7'd21, 16'h1235);                 // entry 5 low via odd byte address
    rd_chk("R4 bit0 ignored on write", 7'd20, 16'h1234);
  endtask

  task automatic t_isolation;
    rd_chk("R10 entry4 lo", 7'd16, 16'h0000);
    rd_chk("R10 entry2 hi", 7'd10, 16'h0000);
    rd_chk("R10 entry5 hi", 7'd22, 16'h0000);
    rd_chk("R10 entry3 lo kept", 7'd12, 16'hABCC);
  endtask

  task automatic t_reloc;
    xl(18'h07FFF, 1'b1);                 // entry 3, offset 1FFF
    check("R5 add", 32'(phys), 32'h3FCBCB);
    check("R8 normal mem_sel", 32'(mem_sel), 1);
    wr(7'd20, 16'hFFFF);
    wr(7'd22, 16'hFFFF);                 // entry 5 = 3FFFFE
    xl(18'h0A005, 1'b1);
    check("R5 wrap", 32'(phys), 32'h000003);
    xl(18'h02010, 1'b1);                 // entry 1 still zero
    check("R5 zero entry", 32'(phys), 32'h000010);
  endtask

  task automatic t_latency;
    @(negedge clk);
    bus_addr = 18'h07FFF; map_en = 1'b1;
    @(posedge clk);
    #1;
    bus_addr = 18'h00004; map_en = 1'b0;
    check("R9 holds sampled value", 32'(phys), 32'h3FCBCB);
    @(negedge clk);
    check("R9 unchanged before edge", 32'(phys), 32'h3FCBCB);
    @(negedge clk);
    check("R9 next value", 32'(phys), 32'h000004);
  endtask

  task automatic t_disabled;
    xl(18'h07FFF, 1'b0);
    check("R6 zero-extend", 32'(phys), 32'h007FFF);
    xl(18'h3DFFF, 1'b0);
    check("R6 top non-io", 32'(phys), 32'h03DFFF);
  endtask

  task automatic t_io;
    wr(7'd124, 16'h5555);
    wr(7'd126, 16'h0015);                // entry 31 loaded
    xl(18'h3E123, 1'b1);
    check("R7 phys en", 32'(phys), 32'h3FE123);
    check("R7 io flag", 32'(io_pg), 1);
    check("R8 io not mem", 32'(mem_sel), 0);
    xl(18'h3FFFF, 1'b0);
    check("R7 phys dis", 32'(phys), 32'h3FFFFF);
    xl(18'h3DFFF, 1'b1);                 // entry 30 zero
    check("R7 io clear", 32'(io_pg), 0);
  endtask

  task automatic t_limits;
    xl(18'h2FFFF, 1'b0);
    check("R8 below lo", 32'(mem_sel), 1);
    xl(18'h30000, 1'b0);
    check("R8 at lo", 32'(mem_sel), 0);
    xl(18'h33FFF, 1'b0);
    check("R8 at hi", 32'(mem_sel), 0);
    xl(18'h34000, 1'b0);
    check("R8 above hi", 32'(mem_sel), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_regs();
    t_isolation();
    t_reloc();
    t_latency();
    t_disabled();
    t_io();
    t_limits();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule